// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by walking a two-level page table held in external memory. The page size is 4 KB. The logical address splits into three fields. The top 10 bits index the outer table. The next 10 bits index an inner table. The low 12 bits are the byte offset within the page.

A walk starts when a requester hands over a logical address. The walker first reads the outer entry at the table base register plus four times the outer index. A valid outer entry names the 4 KB frame that holds the inner table. The walker then reads the inner entry at that frame plus four times the inner index. A valid inner entry gives the frame of the target page. The physical address is that frame with the original offset appended.

If either entry is marked invalid, the walk stops there and a fault is reported, together with the level that failed. Only one walk is in flight at a time, and memory is reached through a single read port. A separate write port loads the table base register.

Top module: `pgwalk_top`

## Requirements
- R1: While reset is asserted, and after it is released with no request made, `req_ready` is 1, and `resp_valid` and `mem_req` are 0.
- R2: After a request is accepted, the first memory read goes to base + 4 × VA[31:22]. `mem_req` stays high with `mem_addr` unchanged until a cycle in which `mem_valid` is 1.
- R3: A table entry is 32 bits. Bit 0 is the valid flag and bits 31:12 are a frame number. Bits 11:1 are ignored. When the outer entry is valid, the second read goes to {outer[31:12], 12'h000} + 4 × VA[21:12].
- R4: When the inner entry is valid, the response has `resp_pa` = {inner[31:12], VA[11:0]}, `resp_fault` = 0 and `resp_fault_lvl` = 0.
- R5: When the outer entry has bit 0 clear, the walk makes no second read. It responds with `resp_fault` = 1, `resp_fault_lvl` = 0 and `resp_pa` = 0.
- R6: When the inner entry has bit 0 clear, the response has `resp_fault` = 1, `resp_fault_lvl` = 1 and `resp_pa` = 0, after exactly two reads.
- R7: `req_ready` is 1 only while no walk is in progress and no response is pending. A `req_valid` raised at any other time is ignored: it causes no memory read and no response.
- R8: Once raised, `resp_valid` and the response fields hold steady until `resp_ready` is 1. In the cycle after that handshake the walker is idle again, with `req_ready` = 1 and `resp_valid` = 0.
- R9: A base write stores `base_wdata` with bits 1:0 forced to zero. A request accepted on the same clock edge as a base write uses the previous base. A base write made during a walk does not change that walk, and it applies to the next walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| base_we | input | 1 | Write enable for the table base register |
| base_wdata | input | 32 | New table base byte address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_va | input | 32 | Logical address to translate |
| resp_valid | output | 1 | Translation result present |
| resp_ready | input | 1 | Requester takes the result |
| resp_pa | output | 32 | Physical address (zero on a fault) |
| resp_fault | output | 1 | An entry on the walk was invalid |
| resp_fault_lvl | output | 1 | Level that faulted: 0 outer, 1 inner |
| mem_req | output | 1 | Table read requested, held until data returns |
| mem_addr | output | 32 | Byte address of the table entry being read |
| mem_valid | input | 1 | Read data present for the current request |
| mem_rdata | input | 32 | Table entry returned by memory |

## Verification
The bench builds the walker with its default split: a 32-bit address, 10-bit outer and inner indices and a 12-bit offset. With this split it can place the outer and inner tables at known frames and reach the extreme index values 0 and 1023. The memory model's latency is changed between walks, from zero wait cycles up to several. This covers the request-hold behaviour and the case where a request is made while a walk is in progress. Base writes are made on the accept edge and in the middle of a walk, which shows which base value each walk uses.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_OUTER = 2'd1,
    WS_INNER = 2'd2,
    WS_DONE  = 2'd3
  } walk_state_e;

endpackage

// File: rtl/pgwalk_rst_sync.sv
module pgwalk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/pgwalk_base_reg.sv
module pgwalk_base_reg #(
  parameter int ADDR_W = 32,
  parameter int ENT_SH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] base_q
);

  logic [ADDR_W-ENT_SH-1:0] hi_q;
  logic [ADDR_W-ENT_SH-1:0] hi_d;

  // word-aligned base: the low bits are never stored
  always_comb begin
    hi_d = wr_data[ADDR_W-1:ENT_SH];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (wr_en) begin
      hi_q <= hi_d;
    end
  end

  assign base_q = {hi_q, {ENT_SH{1'b0}}};

endmodule

// File: rtl/pgwalk_addr_gen.sv
module pgwalk_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int L1_W   = 10,
  parameter int L2_W   = 10,
  parameter int ENT_SH = 2,
  localparam int LOW_W = L2_W + OFF_W,
  localparam int FRM_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [L1_W-1:0]   idx_outer,
  input  logic [LOW_W-1:0]  va_low,
  input  logic [FRM_W-1:0]  pte_frame,
  output logic [ADDR_W-1:0] outer_addr,
  output logic [ADDR_W-1:0] inner_addr,
  output logic [ADDR_W-1:0] pa_ok
);

  logic [ADDR_W-1:0] outer_off;
  logic [ADDR_W-1:0] inner_off;
  logic [ADDR_W-1:0] inner_base;

  // index to byte offset, widened to the address width
  generate
    if (L1_W + ENT_SH < ADDR_W) begin : g_outer_pad
      assign outer_off = {{(ADDR_W-L1_W-ENT_SH){1'b0}}, idx_outer, {ENT_SH{1'b0}}};
    end else begin : g_outer_full
      assign outer_off = ADDR_W'({idx_outer, {ENT_SH{1'b0}}});
    end
    if (L2_W + ENT_SH < ADDR_W) begin : g_inner_pad
      assign inner_off = {{(ADDR_W-L2_W-ENT_SH){1'b0}}, va_low[LOW_W-1:OFF_W], {ENT_SH{1'b0}}};
    end else begin : g_inner_full
      assign inner_off = ADDR_W'({va_low[LOW_W-1:OFF_W], {ENT_SH{1'b0}}});
    end
  endgenerate

  always_comb begin
    inner_base = {pte_frame, {OFF_W{1'b0}}};
    outer_addr = base + outer_off;
    inner_addr = inner_base + inner_off;
    pa_ok      = {pte_frame, va_low[OFF_W-1:0]};
  end

endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
  import pgwalk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LOW_W  = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [LOW_W-1:0]  va_low_in,
  output logic [LOW_W-1:0]  va_low_q,
  input  logic [ADDR_W-1:0] outer_addr,
  input  logic [ADDR_W-1:0] inner_addr,
  input  logic [ADDR_W-1:0] pa_ok,
  input  logic              mem_valid,
  input  logic              pte_valid,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              resp_ready,
  output logic              resp_valid,
  output logic [ADDR_W-1:0] resp_pa,
  output logic              resp_fault,
  output logic              resp_fault_lvl
);

  walk_state_e       state_q, state_d;
  logic              accept;
  logic              step_inner;
  logic              resp_load;
  logic              addr_en;
  logic [ADDR_W-1:0] addr_d;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] pa_d, pa_q;
  logic              flt_d, flt_q;
  logic              lvl_d, lvl_q;

  // next-state and enable logic
  always_comb begin
    state_d    = state_q;
    accept     = 1'b0;
    step_inner = 1'b0;
    resp_load  = 1'b0;
    pa_d       = '0;
    flt_d      = 1'b0;
    lvl_d      = 1'b0;
    unique case (state_q)
      WS_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = WS_OUTER;
        end
      end
      WS_OUTER: begin
        if (mem_valid) begin
          if (pte_valid) begin
            step_inner = 1'b1;
            state_d    = WS_INNER;
          end else begin
            resp_load = 1'b1;
            flt_d     = 1'b1;
            lvl_d     = 1'b0;
            state_d   = WS_DONE;
          end
        end
      end
      WS_INNER: begin
        if (mem_valid) begin
          resp_load = 1'b1;
          state_d   = WS_DONE;
          if (pte_valid) begin
            pa_d = pa_ok;
          end else begin
            flt_d = 1'b1;
            lvl_d = 1'b1;
          end
        end
      end
      WS_DONE: begin
        if (resp_ready) begin
          state_d = WS_IDLE;
        end
      end
      default: state_d = WS_IDLE;
    endcase
    addr_en = accept | step_inner;
    addr_d  = accept ? outer_addr : inner_addr;
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // latched low part of the logical address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_low_q <= '0;
    end else if (accept) begin
      va_low_q <= va_low_in;
    end
  end

  // memory read address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  // response fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q  <= '0;
      flt_q <= 1'b0;
      lvl_q <= 1'b0;
    end else if (resp_load) begin
      pa_q  <= pa_d;
      flt_q <= flt_d;
      lvl_q <= lvl_d;
    end
  end

  assign req_ready      = (state_q == WS_IDLE);
  assign mem_req        = (state_q == WS_OUTER) || (state_q == WS_INNER);
  assign mem_addr       = addr_q;
  assign resp_valid     = (state_q == WS_DONE);
  assign resp_pa        = pa_q;
  assign resp_fault     = flt_q;
  assign resp_fault_lvl = lvl_q;

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int L1_W   = 10,
  parameter int L2_W   = 10,
  parameter int ENT_SH = 2,
  parameter int VLD_B  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_va,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [ADDR_W-1:0] resp_pa,
  output logic              resp_fault,
  output logic              resp_fault_lvl,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [ADDR_W-1:0] mem_rdata
);

  localparam int LOW_W = L2_W + OFF_W;
  localparam int FRM_W = ADDR_W - OFF_W;

  logic              rst_n_int;
  logic [ADDR_W-1:0] base_q;
  logic [LOW_W-1:0]  va_low_q;
  logic [ADDR_W-1:0] outer_addr;
  logic [ADDR_W-1:0] inner_addr;
  logic [ADDR_W-1:0] pa_ok;

  pgwalk_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  pgwalk_base_reg #(.ADDR_W(ADDR_W), .ENT_SH(ENT_SH)) u_base (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (base_we),
    .wr_data (base_wdata),
    .base_q  (base_q)
  );

  pgwalk_addr_gen #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .L1_W(L1_W), .L2_W(L2_W), .ENT_SH(ENT_SH)
  ) u_agen (
    .base       (base_q),
    .idx_outer  (req_va[ADDR_W-1:LOW_W]),
    .va_low     (va_low_q),
    .pte_frame  (mem_rdata[ADDR_W-1:ADDR_W-FRM_W]),
    .outer_addr (outer_addr),
    .inner_addr (inner_addr),
    .pa_ok      (pa_ok)
  );

  pgwalk_fsm #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .va_low_in      (req_va[LOW_W-1:0]),
    .va_low_q       (va_low_q),
    .outer_addr     (outer_addr),
    .inner_addr     (inner_addr),
    .pa_ok          (pa_ok),
    .mem_valid      (mem_valid),
    .pte_valid      (mem_rdata[VLD_B]),
    .mem_req        (mem_req),
    .mem_addr       (mem_addr),
    .resp_ready     (resp_ready),
    .resp_valid     (resp_valid),
    .resp_pa        (resp_pa),
    .resp_fault     (resp_fault),
    .resp_fault_lvl (resp_fault_lvl)
  );

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int VLD_B  = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_va,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic [ADDR_W-1:0] resp_pa,
  input logic              resp_fault,
  input logic              resp_fault_lvl,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_rdata
);

  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (req_valid && req_ready) begin
      off_q <= req_va[OFF_W-1:0];
    end
  end

  a_r7_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req && !resp_valid));

  a_r2_mem_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  a_r5_stop_on_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid && !mem_rdata[VLD_B]) |=> !mem_req);

  a_r5_fault_pa_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_pa == '0));

  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(resp_valid) && !resp_fault) |-> (resp_pa[OFF_W-1:0] == off_q && !resp_fault_lvl));

  a_r8_resp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=>
      (resp_valid && $stable(resp_pa) && $stable(resp_fault) && $stable(resp_fault_lvl)));

  a_r8_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_ready) |=> (req_ready && !resp_valid));

endmodule

bind pgwalk_top pgwalk_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .VLD_B(VLD_B)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n_int),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .req_va         (req_va),
  .resp_valid     (resp_valid),
  .resp_ready     (resp_ready),
  .resp_pa        (resp_pa),
  .resp_fault     (resp_fault),
  .resp_fault_lvl (resp_fault_lvl),
  .mem_req        (mem_req),
  .mem_addr       (mem_addr),
  .mem_valid      (mem_valid),
  .mem_rdata      (mem_rdata)
);

// File: tb/pgwalk_top_tb_top.sv
module pgwalk_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic        base_we;
  logic [31:0] base_wdata;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_va;
  logic        resp_valid;
  logic        resp_ready;
  logic [31:0] resp_pa;
  logic        resp_fault;
  logic        resp_fault_lvl;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid;
  logic [31:0] mem_rdata;

  int n_cmp;
  int n_bad;
  bit done;

  logic [31:0] mem_img [int unsigned];
  logic [31:0] rd_log[$];
  int          lat;
  int          wcnt;
  bit          gave;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  pgwalk_top dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .base_we        (base_we),
    .base_wdata     (base_wdata),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_va         (req_va),
    .resp_valid     (resp_valid),
    .resp_ready     (resp_ready),
    .resp_pa        (resp_pa),
    .resp_fault     (resp_fault),
    .resp_fault_lvl (resp_fault_lvl),
    .mem_req        (mem_req),
    .mem_addr       (mem_addr),
    .mem_valid      (mem_valid),
    .mem_rdata      (mem_rdata)
  );

  // memory model: answers a held request after lat wait cycles
  always @(negedge clk) begin
    mem_valid = 1'b0;
    if (!rst_n) begin
      wcnt = 0;
      gave = 1'b0;
    end else if (mem_req && !gave) begin
      if (wcnt >= lat) begin
        mem_valid = 1'b1;
        mem_rdata = mem_img.exists(mem_addr) ? mem_img[mem_addr] : 32'h0;
        rd_log.push_back(mem_addr);
        wcnt = 0;
        gave = 1'b1;
      end else begin
        wcnt = wcnt + 1;
      end
    end else begin
      gave = 1'b0;
      wcnt = 0;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R8 watchdog expired act=%h exp=%h", 32'h0, 32'h1);
    finish_run();
  end

  // one walk; base write optionally in the accept cycle; hold cycles before taking the answer
  task automatic walk(input logic [31:0] va, input bit bw, input logic [31:0] bdata,
                      input int hold, output logic [31:0] pa, output logic flt,
                      output logic lvl);
    @(negedge clk);
    rd_log.delete();
    req_va    = va;
    req_valid = 1'b1;
    base_we   = bw;
    base_wdata = bdata;
    @(negedge clk);
    req_valid = 1'b0;
    base_we   = 1'b0;
    while (!resp_valid) @(negedge clk);
    pa  = resp_pa;
    flt = resp_fault;
    lvl = resp_fault_lvl;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R8 resp_valid held", {31'h0, resp_valid}, 32'h1);
      check("R8 resp_pa held", resp_pa, pa);
      check("R8 fault held", {30'h0, resp_fault, resp_fault_lvl}, {30'h0, flt, lvl});
    end
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 req_ready in reset", {31'h0, req_ready}, 32'h1);
    check("R1 resp_valid in reset", {31'h0, resp_valid}, 32'h0);
    check("R1 mem_req in reset", {31'h0, mem_req}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 req_ready after reset", {31'h0, req_ready}, 32'h1);
    check("R1 idle outputs after reset", {30'h0, resp_valid, mem_req}, 32'h0);
  endtask

  task automatic t_success(input logic [31:0] va, input int l, input logic [31:0] exp_o,
                           input logic [31:0] exp_i, input logic [31:0] exp_pa);
    logic [31:0] pa;
    logic        f, v;
    lat = l;
    walk(va, 1'b0, 32'h0, 0, pa, f, v);
    check("R2 read count", rd_log.size(), 2);
    if (rd_log.size() == 2) begin
      check("R2 outer read address", rd_log[0], exp_o);
      check("R3 inner read address", rd_log[1], exp_i);
    end
    check("R4 physical address", pa, exp_pa);
    check("R4 no fault", {30'h0, f, v}, 32'h0);
    check("R8 idle after handshake", {30'h0, req_ready, resp_valid}, 32'h2);
  endtask

  task automatic t_outer_fault();
    logic [31:0] pa;
    logic        f, v;
    lat = 2;
    walk(32'h01C0_0123, 1'b0, 32'h0, 0, pa, f, v);
    check("R5 single read", rd_log.size(), 1);
    if (rd_log.size() == 1) check("R5 outer address", rd_log[0], 32'h0001_001C);
    check("R5 fault level 0", {30'h0, f, v}, 32'h2);
    check("R5 pa zero", pa, 32'h0);
  endtask

  task automatic t_inner_fault();
    logic [31:0] pa;
    logic        f, v;
    lat = 1;
    walk(32'h00C0_9010, 1'b0, 32'h0, 0, pa, f, v);
    check("R6 two reads", rd_log.size(), 2);
    if (rd_log.size() == 2) check("R6 inner address", rd_log[1], 32'h0002_0024);
    check("R6 fault level 1", {30'h0, f, v}, 32'h3);
    check("R6 pa zero", pa, 32'h0);
  endtask

  task automatic t_busy();
    lat = 4;
    @(negedge clk);
    rd_log.delete();
    req_va    = 32'h00C0_5ABC;
    req_valid = 1'b1;
    @(negedge clk);
    req_va = 32'h0000_0FFF;
    for (int i = 0; i < 6; i++) begin
      check("R7 not ready while busy", {31'h0, req_ready}, 32'h0);
      @(negedge clk);
    end
    while (!resp_valid) @(negedge clk);
    check("R7 busy request not taken", resp_pa, 32'h0ABC_DABC);
    check("R7 ready low while response pending", {31'h0, req_ready}, 32'h0);
    req_valid  = 1'b0;
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 no extra reads", rd_log.size(), 2);
    check("R7 no extra response", {30'h0, resp_valid, mem_req}, 32'h0);
  endtask

  task automatic t_hold();
    logic [31:0] pa;
    logic        f, v;
    lat = 0;
    walk(32'hFFFF_F000, 1'b0, 32'h0, 5, pa, f, v);
    check("R8 held result", pa, 32'hFFFF_F000);
    check("R8 idle after release", {30'h0, req_ready, resp_valid}, 32'h2);
  endtask

  task automatic t_base();
    logic [31:0] pa;
    logic        f, v;
    lat = 3;
    @(negedge clk);
    rd_log.delete();
    req_va    = 32'h00C0_5ABC;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid  = 1'b0;
    base_we    = 1'b1;
    base_wdata = 32'h0004_0000;
    @(negedge clk);
    base_we = 1'b0;
    while (!resp_valid) @(negedge clk);
    if (rd_log.size() > 0) check("R9 walk keeps old base", rd_log[0], 32'h0001_000C);
    else check("R9 walk made a read", rd_log.size(), 2);
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    walk(32'h00C0_5ABC, 1'b0, 32'h0, 0, pa, f, v);
    if (rd_log.size() > 0) check("R9 new base used", rd_log[0], 32'h0004_000C);
    check("R9 result via new base", pa, 32'h0ABC_DABC);
    // write on the accept edge; low bits of the written base are dropped
    walk(32'h00C0_5ABC, 1'b1, 32'h0005_0003, 0, pa, f, v);
    if (rd_log.size() > 0) check("R9 same-edge write uses old base", rd_log[0], 32'h0004_000C);
    walk(32'h00C0_5ABC, 1'b0, 32'h0, 0, pa, f, v);
    if (rd_log.size() > 0) check("R9 base low bits cleared", rd_log[0], 32'h0005_000C);
    check("R9 missing table faults at outer", {30'h0, f, v}, 32'h2);
  endtask

  initial begin
    n_cmp      = 0;
    n_bad      = 0;
    done       = 1'b0;
    lat        = 0;
    base_we    = 1'b0;
    base_wdata = 32'h0;
    req_valid  = 1'b0;
    req_va     = 32'h0;
    resp_ready = 1'b0;
    mem_rdata  = 32'h0;
    mem_valid  = 1'b0;
    // outer table at 0x10000, second copy at 0x40000
    mem_img[32'h0001_000C] = 32'h0002_0001;
    mem_img[32'h0001_0FFC] = 32'h0003_0FFF;
    mem_img[32'h0001_0000] = 32'h0002_0001;
    mem_img[32'h0004_000C] = 32'h0002_0001;
    // inner tables
    mem_img[32'h0002_0014] = 32'h0ABC_D001;
    mem_img[32'h0003_0FFC] = 32'hFFFF_FFFF;
    mem_img[32'h0002_0000] = 32'h1234_5001;
    mem_img[32'h0002_0024] = 32'h5555_5FFE;

    t_reset();
    @(negedge clk);
    base_we    = 1'b1;
    base_wdata = 32'h0001_0000;
    @(negedge clk);
    base_we = 1'b0;
    t_success(32'h00C0_5ABC, 0, 32'h0001_000C, 32'h0002_0014, 32'h0ABC_DABC);
    t_success(32'hFFFF_F000, 3, 32'h0001_0FFC, 32'h0003_0FFC, 32'hFFFF_F000);
    t_success(32'h0000_0FFF, 1, 32'h0001_0000, 32'h0002_0000, 32'h1234_5FFF);
    t_outer_fault();
    t_inner_fault();
    t_busy();
    t_hold();
    t_base();
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule